// File: doc/BRIEF.md
# Mode Register Write Command Port

This block sits on the controller side of a DRAM memory interface. Software uses it to send one mode-register write to the memory command path. A small word-addressed register bus sets up the request in two parts. A control word holds the rank selection and a launch bit. A payload word holds the mode-register address and its 8-bit value. Setting the launch bit sends the request toward the command path as a single-cycle command, with rank, address and data held alongside it.

A status word reports busy from the launch until the command path returns a completion pulse. Software must poll busy before it programs the next request. The block refuses any write to the control or payload word while a request is outstanding. It records each refused write in a sticky error flag, which software clears by writing a 1 to that flag's bit in the status word. Software usually programs the payload word, then the rank, and then sets the launch bit with a read-modify-write of the control word.

The sequencer has three named states:
- IDLE: nothing is outstanding and writes are accepted.
- ISSUE: the command is on the output for one cycle.
- WAIT: the block waits for the completion pulse.

The transitions are:
- IDLE→ISSUE on an accepted control write with the launch bit set.
- ISSUE→WAIT unconditionally.
- WAIT→IDLE on the completion pulse.

Top module: `mrw_cmd_port`

## Requirements
- R1: After reset, every register word reads zero, the command valid output is low and busy is clear.
- R2: The payload word (word index 1) stores the mode-register address in bits [15:8] and the value in bits [7:0]. Reading it returns these fields, and its other bits read zero.
- R3: The control word (word index 0) stores the rank selection in bits [5:4]. Reading it returns that field. A rank value of 3 (both ranks) reaches the command rank output unchanged.
- R4: An accepted write to the control word with bit 31 set, made while idle, raises command valid in the next cycle. The command carries the rank from that write and the address and value from the payload word.
- R5: Command valid lasts exactly one cycle per launch. Rank, address and value outputs do not change while busy.
- R6: Status bit 0 (busy) reads 1 from the launch cycle until the cycle after the completion pulse. Control bit 31 reads 1 only during the launch cycle.
- R7: While busy, writes to the control or payload word change no stored field and start no command.
- R8: Status bit 1 is a sticky error flag. A write refused under R7 sets it. Writing the status word (word index 2) with bit 1 set clears it.
- R9: A completion pulse when no request is outstanding has no effect. Busy stays clear and no command is issued.
- R10: A control-word write with bit 31 clear only updates the rank and launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word index: 0 control, 1 payload, 2 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| cmd_done | input | 1 | Completion pulse from the command path |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_rank | output | 2 | Rank selection of the command |
| cmd_mr_addr | output | 8 | Mode-register address of the command |
| cmd_mr_data | output | 8 | Value to write |

## Verification
The assertions check every cycle that command valid is a single-cycle pulse following an accepted launch and that the command fields do not move while busy. They also check that busy falls after completion, that a refused write raises the error flag, that the flag stays set until cleared, and that a stray completion pulse leaves the block idle. Only the bench scenarios can show that the stored fields and readback values are right and that the command contents match what software programmed, including rank 3. The scenarios also show that a refused launch produces no extra command, and that the launch bit reads back set only in the launch cycle.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
    localparam int WORD_W   = 32;
    localparam int REG_AW   = 2;
    localparam int RANK_W   = 2;
    localparam int MRA_W    = 8;
    localparam int MRD_W    = 8;

    localparam int RANK_LSB = 4;
    localparam int TRIG_BIT = 31;
    localparam int MRD_LSB  = 0;
    localparam int MRA_LSB  = MRD_LSB + MRD_W;
    localparam int BUSY_BIT = 0;
    localparam int ERR_BIT  = 1;

    localparam logic [REG_AW-1:0] IDX_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] IDX_PAYL = 2'd1;
    localparam logic [REG_AW-1:0] IDX_STAT = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } mrw_state_e;
endpackage

// File: rtl/mrw_fsm.sv
module mrw_fsm
    import mrw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic done_in,
    output logic cmd_valid,
    output logic busy,
    output logic trig_rd
);
    mrw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch_req) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (done_in) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        busy      = 1'b0;
        trig_rd   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                busy      = 1'b1;
                trig_rd   = 1'b1;
            end
            ST_WAIT:  busy = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/mrw_regs.sv
module mrw_regs
    import mrw_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = REG_AW,
    parameter int RW = RANK_W,
    parameter int AMW = MRA_W,
    parameter int DMW = MRD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           busy,
    input  logic           trig_rd,
    output logic [RW-1:0]  rank_q,
    output logic [AMW-1:0] mra_q,
    output logic [DMW-1:0] mrd_q,
    output logic           err_q,
    output logic           launch_req,
    output logic [DW-1:0]  rdata
);
    logic wr_ctrl, wr_payl, wr_stat, refused;

    assign wr_ctrl    = we && (addr == IDX_CTRL);
    assign wr_payl    = we && (addr == IDX_PAYL);
    assign wr_stat    = we && (addr == IDX_STAT);
    assign refused    = (wr_ctrl || wr_payl) && busy;
    assign launch_req = wr_ctrl && !busy && wdata[TRIG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rank_q <= '0;
            mra_q  <= '0;
            mrd_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctrl && !busy) rank_q <= wdata[RANK_LSB +: RW];
            if (wr_payl && !busy) begin
                mra_q <= wdata[MRA_LSB +: AMW];
                mrd_q <= wdata[MRD_LSB +: DMW];
            end
            if (refused)                      err_q <= 1'b1;
            else if (wr_stat && wdata[ERR_BIT]) err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            IDX_CTRL: begin
                rdata[RANK_LSB +: RW] = rank_q;
                rdata[TRIG_BIT]       = trig_rd;
            end
            IDX_PAYL: begin
                rdata[MRA_LSB +: AMW] = mra_q;
                rdata[MRD_LSB +: DMW] = mrd_q;
            end
            IDX_STAT: begin
                rdata[BUSY_BIT] = busy;
                rdata[ERR_BIT]  = err_q;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mrw_cmd_port.sv
module mrw_cmd_port
    import mrw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              cmd_done,
    output logic              cmd_valid,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [MRA_W-1:0]  cmd_mr_addr,
    output logic [MRD_W-1:0]  cmd_mr_data
);
    logic busy, trig_rd, launch_req, err_flag;

    mrw_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .busy       (busy),
        .trig_rd    (trig_rd),
        .rank_q     (cmd_rank),
        .mra_q      (cmd_mr_addr),
        .mrd_q      (cmd_mr_data),
        .err_q      (err_flag),
        .launch_req (launch_req),
        .rdata      (bus_rdata)
    );

    mrw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_req (launch_req),
        .done_in    (cmd_done),
        .cmd_valid  (cmd_valid),
        .busy       (busy),
        .trig_rd    (trig_rd)
    );
endmodule

// File: rtl/mrw_cmd_port_chk.sv
module mrw_cmd_port_chk
    import mrw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              cmd_done,
    input logic              cmd_valid,
    input logic [RANK_W-1:0] cmd_rank,
    input logic [MRA_W-1:0]  cmd_mr_addr,
    input logic [MRD_W-1:0]  cmd_mr_data,
    input logic              busy,
    input logic              err_flag
);
    logic ctrl_launch_wr;
    assign ctrl_launch_wr = bus_we && (bus_addr == IDX_CTRL) && bus_wdata[TRIG_BIT];

    AST_LAUNCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_launch_wr && !busy) |=> cmd_valid); // R4
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R5
    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_rank) && $stable(cmd_mr_addr) && $stable(cmd_mr_data))); // R5
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R6
    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_valid && cmd_done) |=> !busy); // R6
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_valid) |=> !cmd_valid); // R7
    AST_REFUSE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && busy && (bus_addr == IDX_CTRL || bus_addr == IDX_PAYL)) |=> err_flag); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(bus_we && bus_addr == IDX_STAT && bus_wdata[ERR_BIT])) |=> err_flag); // R8
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_done && !ctrl_launch_wr) |=> (!busy && !cmd_valid)); // R9
endmodule

bind mrw_cmd_port mrw_cmd_port_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cmd_done   (cmd_done),
    .cmd_valid  (cmd_valid),
    .cmd_rank   (cmd_rank),
    .cmd_mr_addr(cmd_mr_addr),
    .cmd_mr_data(cmd_mr_data),
    .busy       (busy),
    .err_flag   (err_flag)
);

// File: tb/test_mrw_cmd_port.sv
`timescale 1ns/1ps
module test_mrw_cmd_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cmd_done = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_rank;
    logic [7:0]  cmd_mr_addr;
    logic [7:0]  cmd_mr_data;

    int checks = 0;
    int fails  = 0;
    bit long_hold = 1'b0;
    bit prev_valid = 1'b0;
    logic [17:0] exp_q[$];

    always #2 clk = ~clk;

    mrw_cmd_port i_mrw_cmd_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_done(cmd_done),
        .cmd_valid(cmd_valid), .cmd_rank(cmd_rank), .cmd_mr_addr(cmd_mr_addr),
        .cmd_mr_data(cmd_mr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        do bus_read(2'd2, s); while (s[0]);
    endtask

    // Driver: programs payload and rank, then launches by read-modify-write
    task automatic issue_mrw(input logic [1:0] rk, input logic [7:0] ma, input logic [7:0] md);
        logic [31:0] v;
        wait_idle();
        bus_write(2'd1, {16'h0, ma, md});
        bus_write(2'd0, {26'h0, rk, 4'h0});
        peek(2'd0, v);
        exp_q.push_back({rk, ma, md});
        bus_write(2'd0, v | 32'h8000_0000);
        peek(2'd0, v);
        check("R6 trigger reads 1 in launch cycle", {31'h0, v[31]}, 32'h1);
        peek(2'd2, v);
        check("R6 busy in launch cycle", {31'h0, v[0]}, 32'h1);
        bus_read(2'd0, v);
        check("R6 trigger cleared after launch", {31'h0, v[31]}, 32'h0);
    endtask

    // Monitor / scoreboard: compare each command with the queued expectation
    initial forever begin
        @(negedge clk);
        if (cmd_valid) begin
            if (prev_valid) check("R5 valid width one cycle", 32'h1, 32'h0);
            if (exp_q.size() == 0) begin
                check("R7 unexpected command", {14'h0, cmd_rank, cmd_mr_addr, cmd_mr_data}, 32'h0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check("R4 command fields", {14'h0, cmd_rank, cmd_mr_addr, cmd_mr_data}, {14'h0, e});
            end
        end
        prev_valid = cmd_valid;
    end

    // Completion responder
    initial forever begin
        @(negedge clk);
        if (cmd_valid) begin
            int dly;
            dly = long_hold ? 30 : 1 + int'($urandom % 6);
            repeat (dly) @(negedge clk);
            cmd_done = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd0, v); check("R1 control reset", v, 32'h0);
        peek(2'd1, v);     check("R1 payload reset", v, 32'h0);
        peek(2'd2, v);     check("R1 status reset", v, 32'h0);
        check("R1 valid low", {31'h0, cmd_valid}, 32'h0);

        // R2 payload fields, other bits zero
        bus_write(2'd1, 32'hFFFF_5AC3);
        bus_read(2'd1, v); check("R2 payload readback", v, 32'h0000_5AC3);

        // R3 / R10 rank write without launch
        bus_write(2'd0, 32'h0000_0030);
        peek(2'd0, v); check("R3 rank readback", v, 32'h0000_0030);
        check("R10 no launch", {31'h0, cmd_valid}, 32'h0);
        bus_read(2'd2, v); check("R10 busy clear", v, 32'h0);
        check("R3 rank 3 reaches output", {30'h0, cmd_rank}, 32'h3);

        // R4 several commands
        issue_mrw(2'd3, 8'd13, 8'h4D);
        issue_mrw(2'd1, 8'd1,  8'h00);
        issue_mrw(2'd2, 8'd22, 8'hFF);
        issue_mrw(2'd0, 8'hFF, 8'hA5);
        wait_idle();

        // R7 / R8 refused writes while busy
        long_hold = 1'b1;
        issue_mrw(2'd3, 8'd14, 8'h11);
        bus_write(2'd1, 32'h0000_7788);
        bus_write(2'd0, 32'h8000_0010);
        bus_read(2'd1, v); check("R7 payload unchanged", v, 32'h0000_0E11);
        peek(2'd0, v);     check("R7 rank unchanged", v, 32'h0000_0030);
        peek(2'd2, v);     check("R8 error set while busy", v, 32'h3);
        wait_idle();
        long_hold = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 no extra command", exp_q.size(), 32'h0);
        bus_read(2'd2, v); check("R8 error sticky", v, 32'h2);
        bus_write(2'd2, 32'h0000_0002);
        bus_read(2'd2, v); check("R8 error cleared", v, 32'h0);

        // R9 stray completion
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        peek(2'd2, v); check("R9 busy stays clear", v, 32'h0);
        check("R9 no command", {31'h0, cmd_valid}, 32'h0);
        issue_mrw(2'd1, 8'd2, 8'h36);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R4 queue drained", exp_q.size(), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule